// File: doc/BRIEF.md
# Vector quantizer to 8-bit base-4 float with shared random rounding

This block turns a vector of signed fixed-point values into 8-bit codes of a base-4 floating-point format, one code per lane, in a single registered stage. Each code holds a sign, a 4-bit exponent and a 3-bit mantissa with no hidden bit. A normal code is worth (M/2)·4^(E-7). Exponent 0 holds the subnormal codes, whose mantissa 0 or 1 is weighted by 2^-13. Each exponent step moves the mantissa window by two bit positions.

A mode bit sent with each vector selects how the discarded bits are rounded. Inference traffic rounds to nearest with ties to an even mantissa. Gradient traffic rounds stochastically. For stochastic rounding a uniform random value smaller than one output step is added to the discarded bits, and the sum is then truncated, so the expected result equals the input. One 32-bit Galois LFSR serves every lane. Each lane reads a different rotation of the LFSR state. The state moves on by one step for each accepted vector, and software can reseed it.

Top module: `bq8_quantizer`

## Requirements
- R1: A vector accepted with `in_valid` high produces `out_valid` high and its codes on `out_code` exactly one clock later. In a cycle without `in_valid`, `out_valid` goes low one clock later and `out_code` keeps its previous value.
- R2: Each lane code sits in `out_code[8*i+7:8*i]`, with bit 7 the sign, bits 6:3 the exponent E and bits 2:0 the mantissa M. The input LSB weighs 2^-14. A normal code has E in 1..14, M in 2..7 and the value (M/2)·4^(E-7). The exponent chosen is the largest one that leaves the truncated mantissa at 2 or more.
- R3: A magnitude below 2^-12 after rounding encodes as E=0 with M of 0 or 1, weighted 2^-13. The sign bit always equals the input's sign bit, including for results that round to zero, and an input of zero gives code 0x00.
- R4: When `stoch_mode` is 0, the magnitude rounds to the nearest code. A tie goes to the code with the even mantissa.
- R5: When rounding carries the mantissa from 7 to 8, the result becomes exponent E+1 with mantissa 2. When a subnormal mantissa of 1 rounds up, the result becomes E=1, M=2.
- R6: A magnitude whose rounded result would exceed 3.5·4^7 (57344) saturates to E=14, M=7, which gives code 0x77 or 0xF7. Exponent 15 never appears.
- R7: When `stoch_mode` is 1, a lane with step 2^s (in input LSBs) rounds up exactly when its discarded bits plus the low s bits of its random word reach 2^s. The mean output then tracks the input.
- R8: The LFSR shifts right in Galois form. When the bit shifted out is 1, the state is XORed with 0x80200003 (polynomial x^32+x^22+x^2+x+1). It advances once for each accepted vector in either mode and holds otherwise.
- R9: The random word for lane i is the LFSR state rotated right by i·(32/LANES) bits. A vector uses the state as it stood before that vector's advance.
- R10: `seed_load` takes priority over advancing and writes `seed_val` into the state for the next vector. A seed of zero, and reset, both load 0xACE12468, so the state is never zero.
- R11: During reset, `out_valid` is 0 and `out_code` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Vector on `in_data` is accepted this cycle |
| in_data | input | LANES*IN_W (128) | Signed two's-complement lanes, lane i at bits [IN_W*i +: IN_W] |
| stoch_mode | input | 1 | 1 = stochastic rounding, 0 = round to nearest even |
| seed_load | input | 1 | Replace the LFSR state with `seed_val` |
| seed_val | input | 32 | New LFSR seed (zero maps to the fallback constant) |
| out_valid | output | 1 | `out_code` carries the codes of the vector accepted one cycle earlier |
| out_code | output | LANES*8 (32) | Packed 8-bit codes, lane i at bits [8*i +: 8] |

## Verification
Every code is due one clock after its vector is accepted. A change to the LFSR from an advance or a seed load first shows up in the stochastic results of the next accepted vector. The bench drives inputs on the falling edge, so at each falling edge it compares `out_valid` and every lane against the expectation its model formed one cycle before. In that model, deterministic results come from a nearest-code search over all valid codes, and stochastic results come from a floor-code search combined with a separate LFSR model. A long run in stochastic mode then averages the decoded outputs of each lane and compares the mean with the input value.

// File: rtl/bq8_pkg.sv
package bq8_pkg;

    localparam int unsigned RND_W          = 32;
    localparam logic [31:0] LFSR_TAPS      = 32'h8020_0003;
    localparam logic [31:0] LFSR_FALLBACK  = 32'hACE1_2468;
    localparam int unsigned EXP_TOP        = 14;
    localparam int unsigned CODE_W         = 8;

    typedef struct packed {
        logic       sign;
        logic [3:0] expo;
        logic [2:0] mant;
    } code_t;

endpackage

// File: rtl/bq8_lfsr.sv
module bq8_lfsr
    import bq8_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic             load,
    input  logic [RND_W-1:0] load_val,
    output logic [RND_W-1:0] state
);

    typedef struct packed {
        logic [RND_W-1:0] st;
    } lfsr_reg_t;

    lfsr_reg_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (load) begin
            r_d.st = (load_val == '0) ? LFSR_FALLBACK : load_val;
        end else if (advance) begin
            r_d.st = (r_q.st >> 1) ^ (r_q.st[0] ? LFSR_TAPS : '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{st: LFSR_FALLBACK};
        else        r_q <= r_d;
    end

    assign state = r_q.st;

    // R10: state never collapses to the all-zero lockup value
    assert_state_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);

    // R8: no advance and no load leaves the state untouched
    assert_state_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !load) |=> $stable(state));

endmodule

// File: rtl/bq8_lane.sv
module bq8_lane
    import bq8_pkg::*;
#(
    parameter int unsigned IN_W   = 32,
    parameter int unsigned FRAC_W = 14
) (
    input  logic [IN_W-1:0]  din,
    input  logic [RND_W-1:0] rnd,
    input  logic             stoch,
    output code_t            code
);

    localparam int SH0 = int'(FRAC_W) - 15;
    localparam int WW  = int'(IN_W) + 4;
    localparam int TOP_SH = 2 * int'(EXP_TOP) + SH0;

    logic          neg;
    logic [IN_W-1:0] absv;
    logic [WW-1:0] mag, rem, half, mask, rndw, sum;
    logic [3:0]    e_sel, e_out, mt, mr;
    logic [2:0]    m_out;
    logic          ovf, up;
    int            sft;

    always_comb begin
        neg  = din[IN_W-1];
        absv = neg ? (~din + {{(IN_W-1){1'b0}}, 1'b1}) : din;
        mag  = {{(WW-int'(IN_W)){1'b0}}, absv};

        // pick largest exponent whose truncated mantissa is at least 2
        e_sel = 4'd0;
        sft   = 2 + SH0;
        for (int e = 1; e <= int'(EXP_TOP); e++) begin
            if (mag >= ({{(WW-2){1'b0}}, 2'd2} << (2 * e + SH0))) begin
                e_sel = 4'(e);
                sft   = 2 * e + SH0;
            end
        end
        ovf = (mag >= ({{(WW-4){1'b0}}, 4'd8} << TOP_SH));

        mt   = 4'(mag >> sft);
        mask = ({{(WW-1){1'b0}}, 1'b1} << sft) - {{(WW-1){1'b0}}, 1'b1};
        rem  = mag & mask;
        half = {{(WW-1){1'b0}}, 1'b1} << (sft - 1);
        rndw = WW'(rnd);
        sum  = rem + (rndw & mask);

        if (stoch) up = ((sum >> sft) != '0);
        else       up = (rem > half) || ((rem == half) && mt[0]);

        mr    = mt + {3'b000, up};
        e_out = e_sel;
        m_out = mr[2:0];
        if (mr == 4'd8) begin
            e_out = e_sel + 4'd1;
            m_out = 3'd2;
        end else if ((e_sel == 4'd0) && (mr >= 4'd2)) begin
            e_out = 4'd1;
        end
        if (ovf || (e_out > 4'(EXP_TOP))) begin
            e_out = 4'(EXP_TOP);
            m_out = 3'd7;
        end

        code.sign = neg;
        code.expo = e_out;
        code.mant = m_out;
    end

endmodule

// File: rtl/bq8_quantizer.sv
module bq8_quantizer
    import bq8_pkg::*;
#(
    parameter int unsigned LANES  = 4,
    parameter int unsigned IN_W   = 32,
    parameter int unsigned FRAC_W = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [LANES*IN_W-1:0]   in_data,
    input  logic                    stoch_mode,
    input  logic                    seed_load,
    input  logic [RND_W-1:0]        seed_val,
    output logic                    out_valid,
    output logic [LANES*CODE_W-1:0] out_code
);

    localparam int unsigned ROT = RND_W / LANES;

    typedef struct packed {
        logic                    vld;
        logic [LANES*CODE_W-1:0] codes;
    } out_reg_t;

    out_reg_t o_q, o_d;
    logic [RND_W-1:0]        lfsr_st;
    logic [2*RND_W-1:0]      lfsr_dbl;
    logic [LANES*CODE_W-1:0] lane_codes;

    assign lfsr_dbl = {lfsr_st, lfsr_st};

    bq8_lfsr u_lfsr (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (in_valid),
        .load     (seed_load),
        .load_val (seed_val),
        .state    (lfsr_st)
    );

    for (genvar i = 0; i < int'(LANES); i++) begin : g_lane
        code_t lc;
        bq8_lane #(.IN_W(IN_W), .FRAC_W(FRAC_W)) u_lane (
            .din   (in_data[i*IN_W +: IN_W]),
            .rnd   (lfsr_dbl[i*ROT +: RND_W]),
            .stoch (stoch_mode),
            .code  (lc)
        );
        assign lane_codes[i*CODE_W +: CODE_W] = lc;

        // R6: reserved exponent 15 is never emitted
        assert_no_exp15_R6: assert property (@(posedge clk) disable iff (!rst_n)
            out_code[i*CODE_W+3 +: 4] != 4'hF);

        // R2: normal codes keep a mantissa of 2 or more
        assert_normal_mant_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (out_code[i*CODE_W+3 +: 4] != 4'h0) |-> (out_code[i*CODE_W+1 +: 2] != 2'b00));

        // R3: sign of each code follows the input sign
        assert_sign_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> (out_code[i*CODE_W+7] == $past(in_data[i*IN_W+IN_W-1])));

        // R3: zero input yields the all-zero code
        assert_zero_in_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && (in_data[i*IN_W +: IN_W] == '0)) |=> (out_code[i*CODE_W +: CODE_W] == '0));
    end

    always_comb begin
        o_d     = o_q;
        o_d.vld = in_valid;
        if (in_valid) o_d.codes = lane_codes;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign out_valid = o_q.vld;
    assign out_code  = o_q.codes;

    // R1: output valid trails input valid by one clock
    assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R1: codes hold while no vector is accepted
    assert_hold_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_code)));

endmodule

// File: tb/bq8_quantizer_test.sv
module bq8_quantizer_test;

    localparam int L = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] in_data = '0;
    logic         stoch_mode = 1'b0;
    logic         seed_load = 1'b0;
    logic [31:0]  seed_val = '0;
    logic         out_valid;
    logic [31:0]  out_code;

    always #5 clk = ~clk;

    bq8_quantizer uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .stoch_mode(stoch_mode), .seed_load(seed_load), .seed_val(seed_val),
        .out_valid(out_valid), .out_code(out_code)
    );

    int checks = 0;
    int fails  = 0;

    // ordered table of every valid magnitude code, value in 2^-14 units
    longint      tab_val[86];
    logic [6:0]  tab_code[86];

    logic [31:0] m_lfsr = 32'hACE1_2468;
    logic        exp_vld = 1'b0;
    logic [31:0] exp_codes = '0;
    string       pend_tag = "R11";

    bit          avg_on = 1'b0;
    real         avg_sum[L];
    int          avg_n = 0;

    function automatic logic [31:0] lfsr_step(logic [31:0] s);
        return (s >> 1) ^ (s[0] ? 32'h8020_0003 : 32'h0);
    endfunction

    function automatic longint mag_of(logic [31:0] d);
        longint v = longint'($signed(d));
        return (v < 0) ? -v : v;
    endfunction

    function automatic logic [6:0] ref_nearest(longint mag);
        int     best = 0;
        longint bd = mag;
        for (int k = 1; k < 86; k++) begin
            longint d = (tab_val[k] > mag) ? tab_val[k] - mag : mag - tab_val[k];
            if (d < bd || (d == bd && tab_code[k][0] == 1'b0 && tab_code[best][0] == 1'b1)) begin
                best = k;
                bd   = d;
            end
        end
        return tab_code[best];
    endfunction

    function automatic logic [6:0] ref_stoch(longint mag, logic [31:0] r);
        int     fl = 0;
        longint ulp, u;
        for (int k = 0; k < 86; k++) if (tab_val[k] <= mag) fl = k;
        if (fl == 85) return tab_code[85];
        ulp = tab_val[fl+1] - tab_val[fl];
        u   = longint'(r) & (ulp - 1);
        return ((mag - tab_val[fl]) + u >= ulp) ? tab_code[fl+1] : tab_code[fl];
    endfunction

    function automatic real decode(logic [7:0] c);
        longint units = (c[6:3] == 4'd0) ? longint'(c[2:0]) * 2
                                          : longint'(c[2:0]) << (2 * int'(c[6:3]) - 1);
        return c[7] ? -real'(units) : real'(units);
    endfunction

    task automatic compare();
        checks++;
        if (out_valid !== exp_vld) begin
            fails++;
            $display("FAIL %s out_valid actual %b expected %b", pend_tag, out_valid, exp_vld);
        end
        for (int i = 0; i < L; i++) begin
            checks++;
            if (out_code[i*8 +: 8] !== exp_codes[i*8 +: 8]) begin
                fails++;
                $display("FAIL %s lane %0d code actual %02h expected %02h",
                         pend_tag, i, out_code[i*8 +: 8], exp_codes[i*8 +: 8]);
            end
        end
        if (avg_on && exp_vld) begin
            for (int i = 0; i < L; i++) avg_sum[i] += decode(out_code[i*8 +: 8]);
            avg_n++;
        end
    endtask

    task automatic step(bit v, logic [127:0] d, bit st, bit sl, logic [31:0] sv, string tag);
        @(negedge clk);
        compare();
        in_valid   = v;
        in_data    = d;
        stoch_mode = st;
        seed_load  = sl;
        seed_val   = sv;
        exp_vld    = v;
        if (v) begin
            logic [63:0] dbl = {m_lfsr, m_lfsr};
            for (int i = 0; i < L; i++) begin
                logic [31:0] di = d[i*32 +: 32];
                logic [31:0] ri = dbl[i*8 +: 32];
                logic [6:0]  c7 = st ? ref_stoch(mag_of(di), ri) : ref_nearest(mag_of(di));
                exp_codes[i*8 +: 8] = {di[31], c7};
            end
        end
        if (sl)     m_lfsr = (sv == 32'h0) ? 32'hACE1_2468 : sv;
        else if (v) m_lfsr = lfsr_step(m_lfsr);
        pend_tag = tag;
    endtask

    function automatic logic [31:0] rand_val();
        logic [31:0] m = $urandom >> ($urandom % 32);
        return $urandom_range(0, 1) ? -m : m;
    endfunction

    function automatic logic [127:0] rand_vec();
        return {rand_val(), rand_val(), rand_val(), rand_val()};
    endfunction

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL R1 watchdog actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int n = 0;
        tab_val[n] = 0; tab_code[n] = 7'h00; n++;
        tab_val[n] = 2; tab_code[n] = 7'h01; n++;
        for (int e = 1; e <= 14; e++)
            for (int m = 2; m <= 7; m++) begin
                tab_val[n]  = longint'(m) << (2 * e - 1);
                tab_code[n] = {4'(e), 3'(m)};
                n++;
            end
        for (int i = 0; i < L; i++) avg_sum[i] = 0.0;

        repeat (3) @(negedge clk);
        compare();               // R11 reset state with reset held
        rst_n = 1'b1;

        // R3 zero, subnormal, sign on values rounding to zero
        step(1, {32'd0, 32'd1, -32'd1, 32'd2}, 0, 0, 0, "R11");
        step(1, {32'd3, -32'd3, 32'd5, 32'd4}, 0, 0, 0, "R3");
        // R4 ties to even at exponent 3 and exponent 1
        step(1, {32'd176, 32'd144, -32'd176, 32'd7}, 0, 0, 0, "R5");
        // R5 carry 7.5 into next exponent
        step(1, {32'd240, -32'd240, 32'd15, 32'd239}, 0, 0, 0, "R4");
        // R6 saturation
        step(1, {32'h7FFF_FFFF, 32'h8000_0000, 32'h3800_0000, 32'h3C00_0000}, 0, 0, 0, "R5");
        step(1, {32'h3BFF_FFFF, -32'h3C00_0000, 32'h2000_0000, 32'h1FFF_FFFF}, 0, 0, 0, "R6");
        // R1 idle cycles hold the codes
        step(0, '1, 0, 0, 0, "R6");
        step(0, '0, 1, 0, 0, "R1");
        step(1, {32'd1000, 32'd50000, -32'd123456, 32'd16384}, 0, 0, 0, "R1");
        for (int k = 0; k < 300; k++)
            step(1, rand_vec(), 0, 0, 0, (k == 0) ? "R2" : "R2 R4");
        // R7 R9 stochastic exact against model; R8 advances in both modes
        for (int k = 0; k < 300; k++) begin
            bit v = ($urandom_range(0, 3) != 0);
            step(v, rand_vec(), $urandom_range(0, 3) != 0, 0, 0, "R4 R2");
            pend_tag = "R7 R8 R9";
        end
        // R10 seed load of zero in the same cycle as a vector, then a real seed
        step(1, rand_vec(), 1, 1, 32'h0, "R7 R9");
        step(1, rand_vec(), 1, 0, 0, "R10");
        step(0, '0, 1, 1, 32'h1234_5678, "R10");
        step(1, rand_vec(), 1, 0, 0, "R10");
        step(1, rand_vec(), 1, 1, 32'hDEAD_BEEF, "R10");
        for (int k = 0; k < 40; k++) step(1, rand_vec(), 1, 0, 0, "R10");

        // R7 mean tracks input over many stochastic trials
        step(0, '0, 1, 0, 0, "R7 R9");
        avg_on = 1'b1;
        for (int k = 0; k < 2000; k++)
            step(1, {32'd15336, -32'd868, 32'd1, 32'd170}, 1, 0, 0, "R7");
        step(0, '0, 1, 0, 0, "R7");
        @(negedge clk);
        compare();
        avg_on = 1'b0;
        begin
            real want[L] = '{170.0, 1.0, -868.0, 15336.0};
            real ulp[L]  = '{32.0, 2.0, 128.0, 2048.0};
            for (int i = 0; i < L; i++) begin
                real mean = avg_sum[i] / real'(avg_n);
                real err  = (mean > want[i]) ? mean - want[i] : want[i] - mean;
                checks++;
                if (err > 0.06 * ulp[i]) begin
                    fails++;
                    $display("FAIL R7 lane %0d mean actual %f expected %f", i, mean, want[i]);
                end
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule